// File: doc/BRIEF.md
# Hamming 11-7 Single-Error-Correcting Codec

This block protects a 7-bit data word with four even-parity check bits. It holds two independent paths. The encoder path turns a 7-bit word into an 11-bit codeword. The decoder path takes a received 11-bit word and computes a 4-bit syndrome. When the syndrome names a valid position, the decoder inverts that bit and returns the repaired 7-bit data.

Each path is a single registered stage. Its outputs appear one clock after its input strobe and hold their value until the next strobe. Codeword positions are numbered from 1 to 11, and position p sits at vector bit p-1. The check bits sit at the power-of-two positions. A syndrome value from 12 to 15 cannot point to any bit, so the decoder flags it as uncorrectable and changes no bit.

Top module: `ham_codec`

## Requirements
- R1: The codeword carries data bit d0 at position 3, d1 at 5, d2 at 6, d3 at 7, d4 at 9, d5 at 10 and d6 at 11. Position p is vector bit p-1. The check bit at position 2^j (j = 0..3) makes even parity over every position whose index has bit j set.
- R2: `enc_valid_o` is `enc_valid_i` delayed by exactly one clock, and `enc_code_o` changes only in the cycle after a strobe.
- R3: `dec_syndrome_o` bit j is the even-parity recheck over all received positions whose index has bit j set. The syndrome read as {r8,r4,r2,r1} therefore equals the XOR of the indices of all set positions.
- R4: A zero syndrome gives `dec_err_o`=0, `dec_uncorr_o`=0, and data taken unchanged from the data positions.
- R5: A syndrome from 1 to 11 gives `dec_err_o`=1. The bit at that position is inverted before the data is extracted.
- R6: A syndrome from 12 to 15 gives both `dec_err_o`=1 and `dec_uncorr_o`=1. No bit is inverted in this case.
- R7: While `rst_ni` is low, every output is zero.
- R8: A path whose input strobe is low lowers its output valid one clock later and keeps its data, syndrome and flag outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 7 | Data word to encode |
| enc_valid_o | output | 1 | Encoder output valid |
| enc_code_o | output | 11 | Encoded codeword |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 11 | Received codeword |
| dec_valid_o | output | 1 | Decoder output valid |
| dec_data_o | output | 7 | Corrected data |
| dec_syndrome_o | output | 4 | Syndrome {r8,r4,r2,r1} |
| dec_err_o | output | 1 | Nonzero syndrome seen |
| dec_uncorr_o | output | 1 | Syndrome beyond position 11 |

## Verification
The bench encodes all 128 data words, and each clean codeword is decoded again. This separates the bit placement and the parity coverage from the decoder's no-error path. It then inverts every one of the 11 positions of several codewords, one at a time, so that each syndrome value from 1 to 11 and each inversion target is exercised. All double-bit corruptions of one word, plus hand-built words whose syndromes are 12 to 15, separate miscorrection from the uncorrectable branch. Idle cycles with changing inputs show that the outputs hold their values.

// File: rtl/ham_pkg.sv
package ham_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // smallest r with 2^r >= m + r + 1
  function automatic int unsigned par_width(input int unsigned m);
    int unsigned r;
    r = 1;
    while ((1 << r) < (m + r + 1)) r++;
    return r;
  endfunction

  // 1-based codeword position of data bit k
  function automatic int unsigned data_pos(input int unsigned k);
    int unsigned seen;
    seen = 0;
    for (int unsigned p = 1; p < 1024; p++) begin
      if (!is_pow2(p)) begin
        if (seen == k) return p;
        seen++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/ham_enc.sv
module ham_enc #(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned PAR_W  = ham_pkg::par_width(DATA_W),
  parameter int unsigned CODE_W = DATA_W + PAR_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [PAR_W-1:0] par;

  for (genvar k = 0; k < DATA_W; k++) begin : g_data
    localparam int unsigned Pos = ham_pkg::data_pos(k);
    assign code_o[Pos-1] = data_i[k];
  end

  for (genvar j = 0; j < PAR_W; j++) begin : g_par
    always_comb begin
      par[j] = 1'b0;
      for (int unsigned k = 0; k < DATA_W; k++) begin
        if (((ham_pkg::data_pos(k) >> j) & 1) == 1) par[j] = par[j] ^ data_i[k];
      end
    end
    assign code_o[(1 << j) - 1] = par[j];
  end
endmodule

// File: rtl/ham_syn.sv
module ham_syn #(
  parameter int unsigned CODE_W = 11,
  parameter int unsigned SYN_W  = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [SYN_W-1:0]  syn_o
);
  for (genvar j = 0; j < SYN_W; j++) begin : g_chk
    always_comb begin
      syn_o[j] = 1'b0;
      for (int unsigned p = 1; p <= CODE_W; p++) begin
        if (((p >> j) & 1) == 1) syn_o[j] = syn_o[j] ^ code_i[p-1];
      end
    end
  end
endmodule

// File: rtl/ham_fix.sv
module ham_fix #(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned CODE_W = 11,
  parameter int unsigned SYN_W  = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [SYN_W-1:0]  syn_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              uncorr_o
);
  logic [CODE_W-1:0] flip;
  logic [CODE_W-1:0] fixed;

  // one-hot select of the bit to invert; empty when syndrome is out of range
  for (genvar p = 1; p <= CODE_W; p++) begin : g_flip
    assign flip[p-1] = (syn_i == SYN_W'(p));
  end

  assign fixed    = code_i ^ flip;
  assign err_o    = |syn_i;
  assign uncorr_o = err_o && (flip == '0);

  for (genvar k = 0; k < DATA_W; k++) begin : g_ext
    localparam int unsigned Pos = ham_pkg::data_pos(k);
    assign data_o[k] = fixed[Pos-1];
  end
endmodule

// File: rtl/ham_codec.sv
module ham_codec #(
  parameter int unsigned DATA_W = 7,
  localparam int unsigned PAR_W = ham_pkg::par_width(DATA_W),
  localparam int unsigned CODE_W = DATA_W + PAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [PAR_W-1:0]  dec_syndrome_o,
  output logic              dec_err_o,
  output logic              dec_uncorr_o
);
  logic [CODE_W-1:0] enc_code_d;
  logic [PAR_W-1:0]  syn_d;
  logic [DATA_W-1:0] fix_data_d;
  logic              fix_err_d;
  logic              fix_uncorr_d;

  ham_enc #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_d)
  );

  ham_syn #(.CODE_W(CODE_W), .SYN_W(PAR_W)) u_syn (
    .code_i (dec_code_i),
    .syn_o  (syn_d)
  );

  ham_fix #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SYN_W(PAR_W)) u_fix (
    .code_i   (dec_code_i),
    .syn_i    (syn_d),
    .data_o   (fix_data_d),
    .err_o    (fix_err_d),
    .uncorr_o (fix_uncorr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_code_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o    <= 1'b0;
      dec_data_o     <= '0;
      dec_syndrome_o <= '0;
      dec_err_o      <= 1'b0;
      dec_uncorr_o   <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o     <= fix_data_d;
        dec_syndrome_o <= syn_d;
        dec_err_o      <= fix_err_d;
        dec_uncorr_o   <= fix_uncorr_d;
      end
    end
  end

  // independent recheck of the registered codeword
  logic [PAR_W-1:0] enc_chk_syn;
  ham_syn #(.CODE_W(CODE_W), .SYN_W(PAR_W)) u_chk_syn (
    .code_i (enc_code_o),
    .syn_o  (enc_chk_syn)
  );

  p_enc_zero_syn_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> (enc_chk_syn == '0));

  p_enc_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);

  p_enc_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));

  p_dec_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_err_o == (dec_syndrome_o != '0)));

  p_dec_uncorr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_uncorr_o |-> (dec_err_o && (dec_syndrome_o > PAR_W'(CODE_W))));

  p_dec_corr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_err_o && !dec_uncorr_o) |-> (dec_syndrome_o <= PAR_W'(CODE_W)));

  p_dec_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> (!dec_valid_o && $stable(dec_data_o) && $stable(dec_syndrome_o)));
endmodule

// File: tb/ham_codec_tb.sv
`timescale 1ns/1ps
module ham_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_valid_i = 1'b0;
  logic [6:0]  enc_data_i = '0;
  logic        dec_valid_i = 1'b0;
  logic [10:0] dec_code_i = '0;
  logic        enc_valid_o, dec_valid_o, dec_err_o, dec_uncorr_o;
  logic [10:0] enc_code_o;
  logic [6:0]  dec_data_o;
  logic [3:0]  dec_syndrome_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ham_codec u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o), .dec_err_o(dec_err_o),
    .dec_uncorr_o(dec_uncorr_o)
  );

  // expected state
  logic        x_enc_v = 0, x_dec_v = 0, x_err = 0, x_unc = 0;
  logic [10:0] x_code = '0;
  logic [6:0]  x_data = '0;
  logic [3:0]  x_syn = '0;

  function automatic bit pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [10:0] m_encode(logic [6:0] d);
    logic [10:0] c = '0;
    int k = 0;
    int s = 0;
    for (int p = 1; p <= 11; p++)
      if (!pow2(p)) begin c[p-1] = d[k]; k++; end
    for (int p = 1; p <= 11; p++) if (c[p-1]) s = s ^ p;
    for (int j = 0; j < 4; j++) c[(1 << j) - 1] = s[j];
    return c;
  endfunction

  function automatic logic [3:0] m_syn(logic [10:0] c);
    int s = 0;
    for (int p = 1; p <= 11; p++) if (c[p-1]) s = s ^ p;
    return 4'(s);
  endfunction

  function automatic logic [6:0] m_extract(logic [10:0] c);
    logic [6:0] d = '0;
    int k = 0;
    for (int p = 1; p <= 11; p++)
      if (!pow2(p)) begin d[k] = c[p-1]; k++; end
    return d;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    string dreq;
    dreq = (x_syn == 0) ? "R4" : ((x_syn <= 11) ? "R5" : "R6");
    if (tag != "") dreq = tag;
    check((tag != "") ? tag : "R2", "enc_valid", 32'(enc_valid_o), 32'(x_enc_v));
    check((tag != "") ? tag : "R1", "enc_code", 32'(enc_code_o), 32'(x_code));
    check((tag != "") ? tag : "R2", "dec_valid", 32'(dec_valid_o), 32'(x_dec_v));
    check((tag != "") ? tag : "R3", "syndrome", 32'(dec_syndrome_o), 32'(x_syn));
    check(dreq, "dec_data", 32'(dec_data_o), 32'(x_data));
    check((tag != "") ? tag : "R5", "err", 32'(dec_err_o), 32'(x_err));
    check((tag != "") ? tag : "R6", "uncorr", 32'(dec_uncorr_o), 32'(x_unc));
  endtask

  task automatic step(logic ev, logic [6:0] ed, logic dv, logic [10:0] dc, string tag);
    logic [10:0] fx;
    logic [3:0]  s;
    enc_valid_i = ev; enc_data_i = ed; dec_valid_i = dv; dec_code_i = dc;
    @(posedge clk);
    #1;
    x_enc_v = ev;
    if (ev) x_code = m_encode(ed);
    x_dec_v = dv;
    if (dv) begin
      s = m_syn(dc);
      fx = dc;
      if (s >= 1 && s <= 11) fx[s-1] = ~fx[s-1];
      x_syn = s;
      x_data = m_extract(fx);
      x_err = (s != 0);
      x_unc = (s > 11);
    end
    compare(tag);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [10:0] c;
    // R7: reset state
    repeat (3) @(posedge clk);
    #1;
    compare("R7");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R4: every data word encoded, its clean codeword decoded
    for (int d = 0; d < 128; d++) step(1'b1, 7'(d), 1'b1, m_encode(7'(d)), "");

    // R5: every single-bit inversion on several words
    for (int i = 0; i < 6; i++) begin
      logic [6:0] d;
      d = 7'((i * 37 + 5) & 7'h7f);
      if (i == 0) d = 7'h00;
      if (i == 1) d = 7'h7f;
      for (int p = 1; p <= 11; p++) begin
        c = m_encode(d);
        c[p-1] = ~c[p-1];
        step(1'b0, 7'h00, 1'b1, c, "");
      end
    end

    // R6: double inversions, some landing on syndromes 12..15
    for (int a = 1; a <= 11; a++)
      for (int b = a + 1; b <= 11; b++) begin
        c = m_encode(7'h5a);
        c[a-1] = ~c[a-1];
        c[b-1] = ~c[b-1];
        step(1'b1, 7'(a * 11 + b), 1'b1, c, "");
      end

    // R6: explicit syndromes 12,13,14,15 on otherwise zero words
    step(1'b0, 7'h0, 1'b1, 11'b000_1000_1000, "");
    step(1'b0, 7'h0, 1'b1, 11'b000_1000_1001, "");
    step(1'b0, 7'h0, 1'b1, 11'b000_1000_1010, "");
    step(1'b0, 7'h0, 1'b1, 11'b000_1000_1011, "");

    // R8: idle with changing inputs, outputs hold
    for (int i = 0; i < 8; i++) step(1'b0, 7'(i * 19), 1'b0, 11'(i * 301), "R8");

    // resume: one more active cycle after idle
    step(1'b1, 7'h33, 1'b1, 11'h7ff, "");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule